// File: doc/BRIEF.md
# Serial Host Register Port with Alarm Interrupt

This block is the slave side of a four-wire serial configuration port. An external controller pulls an active-low select, clocks exactly sixteen bits on a serial clock, and so either writes one 8-bit register or reads one back. The first eight bits carry a direction flag and a 7-bit register address. The last eight bits carry the data, least significant bit first. Read data leaves on a serial output that is enabled only while a read is shifting out.

The register space holds a few global configuration registers and one small register group per receive channel. Each group has a control register, a live view of that channel's alarm inputs, and a latch that records every alarm transition. Any latched transition pulls an active-low interrupt. Reading a channel's latch register returns its bits and clears them. A global summary register shows which channels have pending changes.

A mode input enables the port. When it is low the port ignores all traffic, the interrupt stays inactive, and the serial data pin is passed straight through as the mute-disable control. The design samples the serial pins with a fast system clock, so the serial clock must run well below a quarter of that rate.

Top module: `serial_host_port`

## Requirements
- R1: After reset all writable registers read 0x00, `irq_n` is high, and `sdo` and `sdo_oe` are low.
- R2: A write frame is: bit 0 = 0 (write flag), then a 7-bit address MSB first, then 8 data bits LSB first, one bit per rising edge of `sclk` while `cs_n` is low. The register changes when `cs_n` returns high after all 16 clocks.
- R3: A frame with fewer than 16 rising `sclk` edges before `cs_n` rises is discarded and writes nothing.
- R4: A read frame starts with a 1. The addressed register's bit k is driven on `sdo` after falling `sclk` edge 8+k (k = 0..7), so it is valid at rising edge 9+k. `sdo_oe` is low before falling edge 8 and goes low again once `cs_n` is high.
- R5: Rising `sclk` edges beyond the sixteenth in one select cycle are ignored, and the data written is still the bits at positions 9 to 16.
- R6: The register group of channel c starts at 8·(c+1). Offset 0 is a read/write control register driven on `ch_cfg[8c+7:8c]`. Offset 1 reads the channel's live alarm bits. Offset 2 reads its latched alarm changes.
- R7: `irq_n` goes low within three system clocks after any alarm input bit changes in either direction, while host mode is selected.
- R8: Reading a channel's offset-2 register returns its latched changes and then clears them. Reading another channel's latch leaves them alone. `irq_n` returns high when no channel has a pending change.
- R9: Address 0x05 is read-only. Bit c is set when channel c has a pending latched change, and reading it clears nothing.
- R10: With `host_mode` low, frames have no effect, `sdo_oe` stays low, `irq_n` stays high, and `mute_dis` follows `sdi`. With `host_mode` high, `mute_dis` is bit 0 of register 0x00.
- R11: Writes to read-only or unmapped addresses change no register. Reads of unmapped addresses return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| host_mode | input | 1 | 1 enables the serial port; 0 selects pin control |
| cs_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock from the controller |
| sdi | input | 1 | Serial data in; the mute-disable pin when host_mode is 0 |
| alarm_in | input | NCH*ALM_W | Per-channel alarm status bits, channel c at [c*ALM_W +: ALM_W] |
| sdo | output | 1 | Serial read data |
| sdo_oe | output | 1 | Output enable for sdo |
| irq_n | output | 1 | Active-low interrupt (drive low only, open-drain style) |
| mute_dis | output | 1 | Mute-disable control to the channels |
| glb_cfg | output | GLB_RW*8 | Global registers 0x00..0x04, register g at [8g +: 8] |
| ch_cfg | output | NCH*8 | Per-channel control registers |

## Verification
Writes use values with an uneven bit pattern, such as 0xA5, 0x01 and 0x3C, written and read back at several addresses. This shows whether bit order and address order are right and whether the data goes to the right register. Frames of 12, 16 and 20 clocks tell apart three outcomes: a discarded frame, a normal commit, and extra clocks that must be ignored. An alarm raised and then dropped on one channel is followed by reads of the summary register, another channel's latch and the owning latch. This shows whether changes in both directions latch, whether clearing is local to that channel, and whether the summary read leaves the state unchanged. A final pass with host mode off checks that traffic, alarms and the data pin's second role are kept apart.

// File: rtl/shp_pkg.sv
package shp_pkg;
    localparam int NCH       = 4;
    localparam int ALM_W     = 2;
    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 7;
    localparam int CMD_LEN   = ADDR_W + 1;
    localparam int FRAME_LEN = CMD_LEN + DATA_W;
    localparam int GLB_RW    = 5;
    localparam int SUM_ADDR  = 5;
    localparam int CH_BASE   = 8;
    localparam int CH_STRIDE = 8;
    localparam int OFF_CTL   = 0;
    localparam int OFF_LIVE  = 1;
    localparam int OFF_LAT   = 2;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
    } rd_req_t;

    function automatic logic [ADDR_W-1:0] ch_addr(input int ch, input int off);
        return ADDR_W'(CH_BASE + ch * CH_STRIDE + off);
    endfunction

    function automatic logic is_writable(input logic [ADDR_W-1:0] a);
        logic hit;
        hit = (int'(a) < GLB_RW);
        for (int c = 0; c < NCH; c++)
            if (a == ch_addr(c, OFF_CTL)) hit = 1'b1;
        return hit;
    endfunction
endpackage

// File: rtl/shp_frame.sv
module shp_frame
    import shp_pkg::*;
#(
    parameter int P_CMD_LEN = CMD_LEN,
    parameter int P_DATA_W  = DATA_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                host_mode,
    input  logic                cs_n,
    input  logic                sclk,
    input  logic                sdi,
    output rd_req_t             rd_req,
    input  logic [P_DATA_W-1:0] rd_data,
    output wr_req_t             wr_req,
    output logic                sdo,
    output logic                sdo_oe
);
    localparam int LEN   = P_CMD_LEN + P_DATA_W;
    localparam int CNT_W = $clog2(LEN + 1);
    localparam int IDX_W = $clog2(P_DATA_W);

    logic [2:0] cs_sy, ck_sy;
    logic [1:0] di_sy;
    logic       cs_hi, cs_rise, ck_rise, ck_fall, di;

    logic [CNT_W-1:0]     cnt;
    logic [P_CMD_LEN-1:0] cmd;
    logic [P_DATA_W-1:0]  wdat, rd_buf;
    logic                 cap, sdo_q, oe_q;
    wr_req_t              wr_q;
    logic [CNT_W-1:0]     rel;
    logic [IDX_W-1:0]     bidx;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_sy <= '1;
            ck_sy <= '0;
            di_sy <= '0;
        end else begin
            cs_sy <= {cs_sy[1:0], cs_n};
            ck_sy <= {ck_sy[1:0], sclk};
            di_sy <= {di_sy[0], sdi};
        end
    end

    assign cs_hi   = cs_sy[1];
    assign cs_rise = cs_sy[1] & ~cs_sy[2];
    assign ck_rise = ck_sy[1] & ~ck_sy[2];
    assign ck_fall = ~ck_sy[1] & ck_sy[2];
    assign di      = di_sy[1];
    assign rel     = cnt - CNT_W'(P_CMD_LEN);
    assign bidx    = rel[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            cmd    <= '0;
            wdat   <= '0;
            rd_buf <= '0;
            cap    <= 1'b0;
            sdo_q  <= 1'b0;
            oe_q   <= 1'b0;
            wr_q   <= '0;
        end else begin
            cap     <= 1'b0;
            wr_q.en <= 1'b0;
            if (!host_mode || cs_hi) begin
                cnt   <= '0;
                oe_q  <= 1'b0;
                sdo_q <= 1'b0;
                if (host_mode && cs_rise && cnt == CNT_W'(LEN) && !cmd[P_CMD_LEN-1]) begin
                    wr_q.en   <= 1'b1;
                    wr_q.addr <= cmd[P_CMD_LEN-2:0];
                    wr_q.data <= wdat;
                end
            end else begin
                if (ck_rise && cnt < CNT_W'(LEN)) begin
                    cnt <= cnt + 1'b1;
                    if (cnt < CNT_W'(P_CMD_LEN))
                        cmd <= {cmd[P_CMD_LEN-2:0], di};
                    else
                        wdat <= {di, wdat[P_DATA_W-1:1]};
                    if (cnt == CNT_W'(P_CMD_LEN - 1))
                        cap <= 1'b1;
                end
                if (ck_fall && cmd[P_CMD_LEN-1] &&
                    cnt >= CNT_W'(P_CMD_LEN) && cnt < CNT_W'(LEN)) begin
                    sdo_q <= rd_buf[bidx];
                    oe_q  <= 1'b1;
                end
            end
            if (cap && cmd[P_CMD_LEN-1])
                rd_buf <= rd_data;
        end
    end

    assign rd_req.en   = cap & cmd[P_CMD_LEN-1];
    assign rd_req.addr = cmd[P_CMD_LEN-2:0];
    assign wr_req      = wr_q;
    assign sdo         = sdo_q;
    assign sdo_oe      = oe_q;

    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(LEN));
    p_oe_off_r4: assert property (@(posedge clk) disable iff (rst)
        cs_hi |=> !oe_q);
    p_sdo_edge_r4: assert property (@(posedge clk) disable iff (rst)
        (oe_q && $past(oe_q) && !$stable(sdo_q)) |-> $past(ck_fall));
    p_wr_full_r3: assert property (@(posedge clk) disable iff (rst)
        wr_q.en |-> $past(cnt) == CNT_W'(LEN));
    p_hw_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !host_mode |=> (cnt == '0 && !oe_q));
endmodule

// File: rtl/shp_alarm.sv
module shp_alarm
    import shp_pkg::*;
#(
    parameter int P_ALM_W = ALM_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [P_ALM_W-1:0] alm,
    input  logic               clr,
    output logic [P_ALM_W-1:0] latch
);
    logic [P_ALM_W-1:0] prev, lat_q, chg;

    assign chg = alm ^ prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev  <= '0;
            lat_q <= '0;
        end else begin
            prev  <= alm;
            lat_q <= (lat_q & ~{P_ALM_W{clr}}) | chg;
        end
    end

    assign latch = lat_q;

    p_chg_latch_r7: assert property (@(posedge clk) disable iff (rst)
        (alm != prev) |=> (lat_q != '0));
    p_clr_empty_r8: assert property (@(posedge clk) disable iff (rst)
        (clr && alm == prev) |=> (lat_q == '0));
endmodule

// File: rtl/shp_regs.sv
module shp_regs
    import shp_pkg::*;
#(
    parameter int P_NCH    = NCH,
    parameter int P_ALM_W  = ALM_W,
    parameter int P_GLB_RW = GLB_RW
) (
    input  logic                        clk,
    input  logic                        rst,
    input  wr_req_t                     wr_req,
    input  rd_req_t                     rd_req,
    output logic [DATA_W-1:0]           rd_data,
    input  logic [P_NCH*P_ALM_W-1:0]    alarm_in,
    output logic                        irq_any,
    output logic [P_GLB_RW*DATA_W-1:0]  glb_cfg,
    output logic [P_NCH*DATA_W-1:0]     ch_cfg
);
    logic [DATA_W-1:0]  glb_q [P_GLB_RW];
    logic [DATA_W-1:0]  ch_q  [P_NCH];
    logic [P_ALM_W-1:0] lat   [P_NCH];
    logic [P_NCH-1:0]   clr, pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int g = 0; g < P_GLB_RW; g++) glb_q[g] <= '0;
            for (int c = 0; c < P_NCH; c++)    ch_q[c]  <= '0;
        end else if (wr_req.en) begin
            for (int g = 0; g < P_GLB_RW; g++)
                if (wr_req.addr == ADDR_W'(g)) glb_q[g] <= wr_req.data;
            for (int c = 0; c < P_NCH; c++)
                if (wr_req.addr == ch_addr(c, OFF_CTL)) ch_q[c] <= wr_req.data;
        end
    end

    for (genvar c = 0; c < P_NCH; c++) begin : g_ch
        assign clr[c]  = rd_req.en && rd_req.addr == ch_addr(c, OFF_LAT);
        assign pend[c] = |lat[c];
        assign ch_cfg[c*DATA_W +: DATA_W] = ch_q[c];
        shp_alarm #(.P_ALM_W(P_ALM_W)) i_alarm (
            .clk   (clk),
            .rst   (rst),
            .alm   (alarm_in[c*P_ALM_W +: P_ALM_W]),
            .clr   (clr[c]),
            .latch (lat[c])
        );
    end

    for (genvar g = 0; g < P_GLB_RW; g++) begin : g_glb
        assign glb_cfg[g*DATA_W +: DATA_W] = glb_q[g];
    end

    always_comb begin
        rd_data = '0;
        for (int g = 0; g < P_GLB_RW; g++)
            if (rd_req.addr == ADDR_W'(g)) rd_data = glb_q[g];
        if (rd_req.addr == ADDR_W'(SUM_ADDR)) rd_data = DATA_W'(pend);
        for (int c = 0; c < P_NCH; c++) begin
            if (rd_req.addr == ch_addr(c, OFF_CTL))  rd_data = ch_q[c];
            if (rd_req.addr == ch_addr(c, OFF_LIVE)) rd_data = DATA_W'(alarm_in[c*P_ALM_W +: P_ALM_W]);
            if (rd_req.addr == ch_addr(c, OFF_LAT))  rd_data = DATA_W'(lat[c]);
        end
    end

    assign irq_any = |pend;

    p_ro_stable_r11: assert property (@(posedge clk) disable iff (rst)
        (wr_req.en && !is_writable(wr_req.addr)) |=> ($stable(glb_cfg) && $stable(ch_cfg)));
    p_one_clear_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(clr));
endmodule

// File: rtl/serial_host_port.sv
module serial_host_port
    import shp_pkg::*;
#(
    parameter int P_NCH    = NCH,
    parameter int P_ALM_W  = ALM_W,
    parameter int P_GLB_RW = GLB_RW
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       host_mode,
    input  logic                       cs_n,
    input  logic                       sclk,
    input  logic                       sdi,
    input  logic [P_NCH*P_ALM_W-1:0]   alarm_in,
    output logic                       sdo,
    output logic                       sdo_oe,
    output logic                       irq_n,
    output logic                       mute_dis,
    output logic [P_GLB_RW*DATA_W-1:0] glb_cfg,
    output logic [P_NCH*DATA_W-1:0]    ch_cfg
);
    rd_req_t           rd_req;
    wr_req_t           wr_req;
    logic [DATA_W-1:0] rd_data;
    logic              irq_any;

    shp_frame i_frame (
        .clk       (clk),
        .rst       (rst),
        .host_mode (host_mode),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .sdi       (sdi),
        .rd_req    (rd_req),
        .rd_data   (rd_data),
        .wr_req    (wr_req),
        .sdo       (sdo),
        .sdo_oe    (sdo_oe)
    );

    shp_regs #(.P_NCH(P_NCH), .P_ALM_W(P_ALM_W), .P_GLB_RW(P_GLB_RW)) i_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_req   (wr_req),
        .rd_req   (rd_req),
        .rd_data  (rd_data),
        .alarm_in (alarm_in),
        .irq_any  (irq_any),
        .glb_cfg  (glb_cfg),
        .ch_cfg   (ch_cfg)
    );

    assign irq_n    = ~(host_mode & irq_any);
    assign mute_dis = host_mode ? glb_cfg[0] : sdi;

    p_hw_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !host_mode |-> (irq_n && !sdo_oe));
    p_oe_read_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(sdo_oe) |-> !cs_n);
endmodule

// File: tb/test_serial_host_port.sv
module test_serial_host_port;
    import shp_pkg::*;

    localparam int H = 4;

    logic clk = 1'b0;
    logic rst, host_mode, cs_n, sclk, sdi;
    logic [NCH*ALM_W-1:0]  alarm_in;
    logic sdo, sdo_oe, irq_n, mute_dis;
    logic [GLB_RW*8-1:0]   glb_cfg;
    logic [NCH*8-1:0]      ch_cfg;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #4 clk = ~clk;

    serial_host_port i_serial_host_port (
        .clk(clk), .rst(rst), .host_mode(host_mode), .cs_n(cs_n), .sclk(sclk),
        .sdi(sdi), .alarm_in(alarm_in), .sdo(sdo), .sdo_oe(sdo_oe),
        .irq_n(irq_n), .mute_dis(mute_dis), .glb_cfg(glb_cfg), .ch_cfg(ch_cfg)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic rw, input logic [6:0] a, input logic [7:0] d,
                        input int nclk, output logic [7:0] rd,
                        output logic oe7, output logic oe8);
        logic b;
        rd = '0; oe7 = 1'b0; oe8 = 1'b0;
        @(negedge clk);
        cs_n = 1'b0; sclk = 1'b0;
        repeat (H) @(negedge clk);
        for (int i = 0; i < nclk; i++) begin
            if (i == 0)      b = rw;
            else if (i < 8)  b = a[7-i];
            else if (i < 16) b = d[i-8];
            else             b = 1'b1;
            sclk = 1'b0; sdi = b;
            repeat (H) @(negedge clk);
            if (i == 7) oe7 = sdo_oe;
            if (i >= 8 && i < 16) begin
                rd[i-8] = sdo;
                if (i == 8) oe8 = sdo_oe;
            end
            sclk = 1'b1;
            repeat (H) @(negedge clk);
        end
        sclk = 1'b0;
        repeat (H) @(negedge clk);
        cs_n = 1'b1; sdi = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic wr(input logic [6:0] a, input logic [7:0] d, input int n);
        logic [7:0] r; logic x, y;
        xfer(1'b0, a, d, n, r, x, y);
    endtask

    task automatic rd(input logic [6:0] a, output logic [7:0] r);
        logic x, y;
        xfer(1'b1, a, 8'h00, 16, r, x, y);
    endtask

    task automatic t_reset();
        chk("R1 irq_n", int'(irq_n), 1);
        chk("R1 sdo_oe", int'(sdo_oe), 0);
        chk("R1 sdo", int'(sdo), 0);
        chk("R1 glb_cfg", int'(glb_cfg), 0);
        chk("R1 ch_cfg", int'(ch_cfg), 0);
    endtask

    task automatic t_write_read();
        logic [7:0] r; logic o7, o8;
        wr(7'h02, 8'hA5, 16);
        chk("R2 glb reg2", int'(glb_cfg[23:16]), 'hA5);
        xfer(1'b1, 7'h02, 8'h00, 16, r, o7, o8);
        chk("R4 read 0x02", int'(r), 'hA5);
        chk("R4 oe before fall 8", int'(o7), 0);
        chk("R4 oe after fall 8", int'(o8), 1);
        chk("R4 oe after cs high", int'(sdo_oe), 0);
        wr(7'h00, 8'h01, 16);
        chk("R2 glb reg0 lsb", int'(glb_cfg[7:0]), 'h01);
        chk("R10 mute_dis host", int'(mute_dis), 1);
        rd(7'h00, r);
        chk("R4 read 0x00 lsb first", int'(r), 'h01);
    endtask

    task automatic t_channels();
        logic [7:0] r;
        for (int c = 0; c < NCH; c++) wr(7'(8*(c+1)), 8'(8'h10 + c*8'h11), 16);
        for (int c = 0; c < NCH; c++) begin
            chk("R6 ch_cfg slice", int'(ch_cfg[c*8 +: 8]), 'h10 + c*'h11);
            rd(7'(8*(c+1)), r);
            chk("R6 ch ctl read", int'(r), 'h10 + c*'h11);
        end
    endtask

    task automatic t_frame_len();
        wr(7'h03, 8'h5A, 12);
        chk("R3 short frame dropped", int'(glb_cfg[31:24]), 0);
        wr(7'h04, 8'h3C, 20);
        chk("R5 long frame data", int'(glb_cfg[39:32]), 'h3C);
    endtask

    task automatic t_unmapped();
        logic [7:0] r;
        logic [GLB_RW*8-1:0] g0;
        logic [NCH*8-1:0] c0;
        g0 = glb_cfg; c0 = ch_cfg;
        wr(7'h30, 8'hFF, 16);
        wr(7'h05, 8'hFF, 16);
        wr(7'h11, 8'hFF, 16);
        chk("R11 glb unchanged", int'(glb_cfg == g0), 1);
        chk("R11 ch unchanged", int'(ch_cfg == c0), 1);
        rd(7'h30, r);
        chk("R11 unmapped read", int'(r), 0);
        rd(7'h05, r);
        chk("R11 summary not written", int'(r), 0);
    endtask

    task automatic t_alarm();
        logic [7:0] r;
        @(negedge clk);
        alarm_in[2*ALM_W] = 1'b1;
        repeat (3) @(negedge clk);
        chk("R7 irq on rise", int'(irq_n), 0);
        rd(7'h05, r);
        chk("R9 summary ch2", int'(r), 'h04);
        chk("R9 summary keeps irq", int'(irq_n), 0);
        rd(7'h12, r);
        chk("R8 other latch", int'(r), 0);
        chk("R8 other read keeps irq", int'(irq_n), 0);
        rd(7'h19, r);
        chk("R6 live alarm ch2", int'(r), 'h01);
        rd(7'h1A, r);
        chk("R8 latch ch2", int'(r), 'h01);
        chk("R8 irq released", int'(irq_n), 1);
        rd(7'h1A, r);
        chk("R8 latch cleared", int'(r), 0);
        @(negedge clk);
        alarm_in[2*ALM_W] = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7 irq on fall", int'(irq_n), 0);
        rd(7'h1A, r);
        chk("R8 latch after fall", int'(r), 'h01);
        chk("R8 irq released again", int'(irq_n), 1);
    endtask

    task automatic t_hw_mode();
        logic [7:0] r; logic o7, o8;
        @(negedge clk);
        host_mode = 1'b0;
        sdi = 1'b1;
        @(negedge clk);
        chk("R10 mute_dis pin 1", int'(mute_dis), 1);
        sdi = 1'b0;
        @(negedge clk);
        chk("R10 mute_dis pin 0", int'(mute_dis), 0);
        wr(7'h01, 8'h77, 16);
        chk("R10 write ignored", int'(glb_cfg[15:8]), 0);
        xfer(1'b1, 7'h02, 8'h00, 16, r, o7, o8);
        chk("R10 no sdo_oe", int'(o8), 0);
        alarm_in[0] = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10 irq held high", int'(irq_n), 1);
        host_mode = 1'b1;
        repeat (2) @(negedge clk);
        chk("R7 irq after host", int'(irq_n), 0);
        rd(7'h0A, r);
        chk("R8 latch ch0", int'(r), 'h01);
        chk("R8 irq clear ch0", int'(irq_n), 1);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; host_mode = 1'b1; cs_n = 1'b1; sclk = 1'b0; sdi = 1'b0;
        alarm_in = '0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        t_reset();
        t_write_read();
        t_channels();
        t_frame_len();
        t_unmapped();
        t_alarm();
        t_hw_mode();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule